// File: doc/BRIEF.md
# String Operation Address Stepper

This block carries out a single element of a string primitive on behalf of an instruction sequencer. Three kinds of element are supported: load (fetch one element into the accumulator), scan (test the accumulator against one element in the destination segment) and compare (test an element in the source segment against one in the destination segment). For each command it builds 20-bit segmented addresses, issues one or two reads on a request/response memory port, and returns the new accumulator, the new source and destination pointers, and, for scan and compare, a set of subtraction flags.

A command is presented with all the register values it needs, so the block keeps no architectural state of its own. Commands, memory requests and results each use a valid/ready pair. The sender of a command holds it until `cmd_ready` is high. The block holds a memory request, with address and size unchanged, until `mem_req_ready` is high. It holds a result, with every field unchanged, until `res_ready` is high. Only one command is in flight at a time. The memory port has no ready on the response side: exactly one `mem_rsp_valid` pulse is expected per accepted request.

Top module: `str_elem_stepper`

## Requirements
- R1: After reset `cmd_ready` is 1 and `mem_req_valid` and `res_valid` are 0. `cmd_ready` is high only when no command is in flight. The `cmd_op` codes are 0 = load, 1 = scan, 2 = compare, and 3 behaves exactly as load.
- R2: Every read address is (segment × 16 + offset) truncated to 20 bits.
- R3: Load, and the first read of compare, use the source segment at offset SI. The source segment is `cmd_ds`, or `cmd_ovr_seg` when `cmd_ovr_en` is 1.
- R4: Scan reads the destination segment `cmd_es` at offset DI, and it ignores `cmd_ovr_en`.
- R5: Compare issues two reads: the source element first, then ES:DI. It subtracts the destination element from the source element for its flags.
- R6: `mem_req_word` equals `cmd_word`, and word data is little-endian in `mem_rsp_data`. A byte load replaces only the low byte of the accumulator and keeps the high byte. A word load replaces all 16 bits. Scan and compare return the accumulator unchanged.
- R7: A pointer that moves steps by 1 for bytes and 2 for words. It increments when `cmd_dir` is 0 and decrements when `cmd_dir` is 1, wrapping within 16 bits. Load moves only SI, scan moves only DI, and compare moves both.
- R8: `res_flags` bits are {5: overflow, 4: sign, 3: zero, 2: auxiliary, 1: parity, 0: carry}. They are computed for minuend − subtrahend at the element width. Carry is the borrow out of the top bit. Auxiliary is the borrow out of bit 3. Parity is 1 when the low 8 result bits hold an even number of ones. `res_flags_upd` is 1 for scan and compare and 0 for load.
- R9: `res_valid` rises in the cycle after the response to the last read. A pending memory request and a pending result both stay stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 load, 1 scan, 2 compare, 3 load |
| cmd_word | input | 1 | 1 = 16-bit element, 0 = 8-bit element |
| cmd_dir | input | 1 | 1 = pointers decrement |
| cmd_ovr_en | input | 1 | Replace the source segment |
| cmd_ovr_seg | input | 16 | Replacement source segment |
| cmd_ds | input | 16 | Default source segment |
| cmd_es | input | 16 | Destination segment |
| cmd_si | input | 16 | Source pointer |
| cmd_di | input | 16 | Destination pointer |
| cmd_ax | input | 16 | Accumulator |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Physical byte address |
| mem_req_word | output | 1 | Request is a 16-bit read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 16 | Read data, lower address in bits 7:0 |
| res_valid | output | 1 | Result pending |
| res_ready | input | 1 | Consumer accepts the result |
| res_ax | output | 16 | New accumulator |
| res_si | output | 16 | New source pointer |
| res_di | output | 16 | New destination pointer |
| res_flags | output | 6 | Subtraction flags |
| res_flags_upd | output | 1 | Flags are meaningful |

## Verification
Loads are run in both directions and at both widths, with and without a segment replacement, and with pointer and address values next to the 16-bit and 20-bit wrap points. These runs separate the choice of segment from the step arithmetic. Scans use element values chosen to give equality, a signed overflow with a low-nibble borrow, and a full-width borrow. Each of these drives a different subset of the flags, and one scan has the replacement enabled to show that the segment is still the destination segment. Compares at both widths check the read order and that both pointers move, and the reserved opcode is compared against a load. Random stalls on both ready inputs exercise holding under back-pressure and the one-cycle completion timing.

// File: rtl/str_step_pkg.sv
package str_step_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SCAN = 2'd1,
    OP_CMP  = 2'd2,
    OP_ALT  = 2'd3
  } str_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } str_state_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } sub_flags_t;
endpackage

// File: rtl/str_phys_addr.sv
module str_phys_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int SUM_W = SEG_W + SHIFT + 1;
  logic [SUM_W-1:0] sum;
  always_comb begin
    sum  = {1'b0, seg, {SHIFT{1'b0}}} + SUM_W'(off);
    addr = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/str_ptr_step.sv
module str_ptr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         word,
  input  logic         down,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] step;
  always_comb begin
    step  = word ? W'(2) : W'(1);
    ptr_o = down ? (ptr_i - step) : (ptr_i + step);
  end
endmodule

// File: rtl/str_sub_flags.sv
module str_sub_flags
  import str_step_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output sub_flags_t   f
);
  logic [W:0]   diff;
  logic [W-1:0] r;
  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    r    = diff[W-1:0];
    f.cf = diff[W];
    f.zf = (r == '0);
    f.sf = r[W-1];
    f.of = (a[W-1] ^ b[W-1]) & (a[W-1] ^ r[W-1]);
    f.af = (a[3:0] < b[3:0]);
    f.pf = ~^r[7:0];
  end

  // Equal operands give no borrow, no sign and no overflow (R8)
  always_comb begin
    if (f.zf) begin
      assert_zero_no_borrow_R8: assert (!f.cf && !f.sf && !f.of && !f.af);
    end
  end
endmodule

// File: rtl/str_elem_stepper.sv
module str_elem_stepper
  import str_step_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_word,
  input  logic              cmd_dir,
  input  logic              cmd_ovr_en,
  input  logic [REG_W-1:0]  cmd_ovr_seg,
  input  logic [REG_W-1:0]  cmd_ds,
  input  logic [REG_W-1:0]  cmd_es,
  input  logic [REG_W-1:0]  cmd_si,
  input  logic [REG_W-1:0]  cmd_di,
  input  logic [REG_W-1:0]  cmd_ax,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_word,
  input  logic              mem_rsp_valid,
  input  logic [REG_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [REG_W-1:0]  res_ax,
  output logic [REG_W-1:0]  res_si,
  output logic [REG_W-1:0]  res_di,
  output logic [5:0]        res_flags,
  output logic              res_flags_upd
);
  localparam int BYTE_W = 8;

  str_state_e       state_q;
  str_op_e          op_q;
  logic             phase_q, word_q, dir_q, ovr_en_q;
  logic [REG_W-1:0] ovr_q, ds_q, es_q, si_q, di_q, ax_q, d0_q, d1_q;

  logic             is_load, use_dst, moves_si, moves_di;
  logic [REG_W-1:0] seg_sel, off_sel, si_next, di_next, opa, opb;
  sub_flags_t       flg [2];

  always_comb begin
    is_load  = (op_q == OP_LOAD) || (op_q == OP_ALT);
    use_dst  = (op_q == OP_SCAN) || phase_q;
    moves_si = is_load || (op_q == OP_CMP);
    moves_di = (op_q == OP_SCAN) || (op_q == OP_CMP);
    seg_sel  = use_dst ? es_q : (ovr_en_q ? ovr_q : ds_q);
    off_sel  = use_dst ? di_q : si_q;
    opa      = (op_q == OP_CMP) ? d0_q : ax_q;
    opb      = (op_q == OP_CMP) ? d1_q : d0_q;
  end

  str_phys_addr #(.SEG_W(REG_W), .OFF_W(REG_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W))
    u_addr (.seg(seg_sel), .off(off_sel), .addr(mem_req_addr));

  str_ptr_step #(.W(REG_W)) u_si_step (.ptr_i(si_q), .word(word_q), .down(dir_q), .ptr_o(si_next));
  str_ptr_step #(.W(REG_W)) u_di_step (.ptr_i(di_q), .word(word_q), .down(dir_q), .ptr_o(di_next));

  // One flag unit per element width: index 0 bytes, index 1 words
  for (genvar g = 0; g < 2; g++) begin : g_flags
    localparam int FW = (g == 0) ? BYTE_W : REG_W;
    str_sub_flags #(.W(FW)) u_flags (.a(opa[FW-1:0]), .b(opb[FW-1:0]), .f(flg[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_LOAD;
      phase_q  <= 1'b0;
      word_q   <= 1'b0;
      dir_q    <= 1'b0;
      ovr_en_q <= 1'b0;
      ovr_q    <= '0;
      ds_q     <= '0;
      es_q     <= '0;
      si_q     <= '0;
      di_q     <= '0;
      ax_q     <= '0;
      d0_q     <= '0;
      d1_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          op_q     <= str_op_e'(cmd_op);
          word_q   <= cmd_word;
          dir_q    <= cmd_dir;
          ovr_en_q <= cmd_ovr_en;
          ovr_q    <= cmd_ovr_seg;
          ds_q     <= cmd_ds;
          es_q     <= cmd_es;
          si_q     <= cmd_si;
          di_q     <= cmd_di;
          ax_q     <= cmd_ax;
          phase_q  <= 1'b0;
          state_q  <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!phase_q) d0_q <= mem_rsp_data;
          else          d1_q <= mem_rsp_data;
          if (op_q == OP_CMP && !phase_q) begin
            phase_q <= 1'b1;
            state_q <= ST_REQ;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_REQ);
    mem_req_word  = word_q;
    res_valid     = (state_q == ST_DONE);
    res_flags_upd = !is_load;
    res_ax        = !is_load ? ax_q : (word_q ? d0_q : {ax_q[REG_W-1:BYTE_W], d0_q[BYTE_W-1:0]});
    res_si        = moves_si ? si_next : si_q;
    res_di        = moves_di ? di_next : di_q;
    res_flags     = is_load ? 6'd0 : (word_q ? flg[1] : flg[0]);
  end

  assert_idle_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !res_valid);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_word));

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ax) && $stable(res_si)
                                && $stable(res_di) && $stable(res_flags));

  assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(mem_rsp_valid));

  assert_load_keeps_di_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && is_load |-> res_di == di_q && !res_flags_upd);

  assert_scan_keeps_si_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && op_q == OP_SCAN |-> res_si == si_q && res_ax == ax_q);
endmodule

// File: tb/str_elem_stepper_bench.sv
`timescale 1ns/1ps
module str_elem_stepper_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_word = 0, cmd_dir = 0, cmd_ovr_en = 0;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_ovr_seg = 0, cmd_ds = 0, cmd_es = 0, cmd_si = 0, cmd_di = 0, cmd_ax = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_word, mem_rsp_valid = 0;
  logic [19:0] mem_req_addr;
  logic [15:0] mem_rsp_data = 0;
  logic res_valid, res_ready = 0, res_flags_upd;
  logic [15:0] res_ax, res_si, res_di;
  logic [5:0] res_flags;

  str_elem_stepper u_str_elem_stepper (.*);

  typedef struct packed { logic [15:0] ax, si, di; logic upd; logic [5:0] fl; } exp_res_t;
  typedef struct packed { logic [19:0] addr; logic word; logic last; } exp_req_t;
  exp_res_t res_q[$];
  exp_req_t req_q[$];
  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(logic [15:0] seg, logic [15:0] off);
    return 20'(({4'd0, seg} << 4) + {4'd0, off});
  endfunction

  function automatic logic [15:0] rd(logic [19:0] a, logic w);
    logic [7:0] lo, hi;
    lo = mem[a[7:0]];
    hi = mem[8'(a[7:0] + 8'd1)];
    return w ? {hi, lo} : {8'd0, lo};
  endfunction

  function automatic logic [5:0] subfl(logic [15:0] a, logic [15:0] b, logic w);
    int n, ua, ub, d, r, sa, sb, sd;
    logic of, sf, zf, af, pf, cf;
    n  = w ? 16 : 8;
    ua = w ? int'(a) : int'(a[7:0]);
    ub = w ? int'(b) : int'(b[7:0]);
    d  = ua - ub;
    r  = d & ((1 << n) - 1);
    sa = (ua >= (1 << (n - 1))) ? ua - (1 << n) : ua;
    sb = (ub >= (1 << (n - 1))) ? ub - (1 << n) : ub;
    sd = sa - sb;
    cf = (ua < ub);
    zf = (r == 0);
    sf = ((r >> (n - 1)) & 1) == 1;
    of = (sd > (1 << (n - 1)) - 1) || (sd < -(1 << (n - 1)));
    af = ((ua & 15) < (ub & 15));
    pf = ($countones(r & 255) % 2) == 0;
    return {of, sf, zf, af, pf, cf};
  endfunction

  // Driver: computes expectations from the requirements and pushes them
  task automatic run(logic [1:0] op, logic w, logic dn, logic oen, logic [15:0] ovr,
                     logic [15:0] ds, logic [15:0] es, logic [15:0] si, logic [15:0] di,
                     logic [15:0] ax);
    logic [15:0] src, st, d0, d1;
    logic [19:0] a0, a1;
    exp_res_t e;
    st  = w ? 16'd2 : 16'd1;
    src = oen ? ovr : ds;
    e.ax = ax; e.si = si; e.di = di; e.upd = 0; e.fl = 0;
    if (op == 2'd1) begin
      a0 = phys(es, di);
      req_q.push_back('{a0, w, 1'b1});
      d0 = rd(a0, w);
      e.di = dn ? di - st : di + st;
      e.upd = 1; e.fl = subfl(ax, d0, w);
    end else if (op == 2'd2) begin
      a0 = phys(src, si);
      a1 = phys(es, di);
      req_q.push_back('{a0, w, 1'b0});
      req_q.push_back('{a1, w, 1'b1});
      d0 = rd(a0, w); d1 = rd(a1, w);
      e.si = dn ? si - st : si + st;
      e.di = dn ? di - st : di + st;
      e.upd = 1; e.fl = subfl(d0, d1, w);
    end else begin
      a0 = phys(src, si);
      req_q.push_back('{a0, w, 1'b1});
      d0 = rd(a0, w);
      e.ax = w ? d0 : {ax[15:8], d0[7:0]};
      e.si = dn ? si - st : si + st;
    end
    res_q.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_word = w; cmd_dir = dn; cmd_ovr_en = oen; cmd_ovr_seg = ovr;
    cmd_ds = ds; cmd_es = es; cmd_si = si; cmd_di = di; cmd_ax = ax; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    while (res_q.size() != 0) @(negedge clk);
  endtask

  logic [7:0] lf = 8'hA7;
  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};

  // Memory responder: checks request address and size, answers after 0..2 cycles
  initial begin
    bit pend = 0, last = 0, after = 0;
    int lat = 0;
    logic [19:0] pa;
    logic pw;
    exp_req_t x;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (after) chk("R9 res_valid one cycle after last response", res_valid, 1);
      after = 0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd(pa, pw);
          pend = 0; after = last;
        end else lat--;
      end
      mem_req_ready = lf[0] && !pend && !mem_rsp_valid;
      if (mem_req_valid && mem_req_ready) begin
        if (req_q.size() == 0) chk("R1 unexpected request", 1, 0);
        else begin
          x = req_q.pop_front();
          chk("R2 R3 R4 R5 read address", mem_req_addr, x.addr);
          chk("R6 request size", mem_req_word, x.word);
          pa = mem_req_addr; pw = mem_req_word; last = x.last;
          pend = 1; lat = int'(lf[2:1]) % 3;
        end
      end
    end
  end

  // Monitor: pops expected results and compares, and checks holding under stall
  initial begin
    exp_res_t e;
    logic [54:0] snap;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk("R9 result held under stall", {res_valid, res_ax, res_si, res_di, res_flags_upd, res_flags},
            {1'b1, snap});
      end
      res_ready = lf[3] | lf[6];
      stalled = res_valid && !res_ready;
      snap = {res_ax, res_si, res_di, res_flags_upd, res_flags};
      if (res_valid && res_ready) begin
        if (res_q.size() == 0) chk("R1 unexpected result", 1, 0);
        else begin
          e = res_q.pop_front();
          chk("R6 accumulator", res_ax, e.ax);
          chk("R7 source pointer", res_si, e.si);
          chk("R7 destination pointer", res_di, e.di);
          chk("R8 flags valid", res_flags_upd, e.upd);
          if (e.upd) chk("R8 flags", res_flags, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'h40] = 8'h01;
    mem[8'h50] = 8'h01; mem[8'h51] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cmd_ready", cmd_ready, 1);
    chk("R1 reset mem_req_valid", mem_req_valid, 0);
    chk("R1 reset res_valid", res_valid, 0);
    // load byte, up, default segment: AH kept
    run(2'd0, 0, 0, 0, 16'h0000, 16'h1000, 16'h2000, 16'h0010, 16'h0300, 16'hAB00);
    // load word, down, override, SI wraps below zero
    run(2'd0, 1, 1, 1, 16'h2345, 16'h1000, 16'h2000, 16'h0001, 16'h0300, 16'h1234);
    // load word, up, address wraps past 20 bits, SI wraps above 0xFFFF
    run(2'd0, 1, 0, 0, 16'h0000, 16'hFFFF, 16'h2000, 16'hFFFF, 16'h0300, 16'h0000);
    // scan byte equal, override enabled but ignored (R4)
    run(2'd1, 0, 0, 1, 16'h7777, 16'h1000, 16'h0123, 16'h0045, 16'h5500,
        {8'h55, rd(phys(16'h0123, 16'h0045), 0)[7:0]});
    // scan byte 0x80 - 0x01: signed overflow, nibble borrow
    run(2'd1, 0, 1, 0, 16'h0000, 16'h1000, 16'h0004, 16'h0000, 16'h0000, 16'h0080);
    // scan word 0 - 1: full borrow, DI wraps down
    run(2'd1, 1, 1, 0, 16'h0000, 16'h1000, 16'h0005, 16'h0000, 16'h0000, 16'h0000);
    // compare byte up with override
    run(2'd2, 0, 0, 1, 16'h0400, 16'h1000, 16'h0800, 16'h0021, 16'h0033, 16'h9999);
    // compare word down
    run(2'd2, 1, 1, 0, 16'h0000, 16'h0100, 16'h0005, 16'h0010, 16'h0000, 16'h4242);
    // reserved code behaves as load
    run(2'd3, 0, 1, 0, 16'h0000, 16'h0030, 16'h2000, 16'h0007, 16'h1111, 16'hCDEF);
    repeat (5) @(negedge clk);
    chk("R1 idle after all commands", cmd_ready, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule